// File: doc/BRIEF.md
# Synchronous Tri-Port Bus Exchanger

This block is a registered, bidirectional exchanger for interleaved memory. One processor-side port A links to two memory-side ports: B1 serves the even bank and B2 serves the odd bank. All three ports have the same width. Four data registers share one clock:

- A into B1
- A into B2
- B1 back to A
- B2 back to A

Each data register has its own active-low load enable. The return-path select and the two output enables are captured on the rising edge. A change of direction or path therefore takes effect at an edge, never in the middle of a cycle.

Each bidirectional pin is modelled as three signals:

- an output value with an output-enable flag;
- an external value with a valid flag, which tells whether something outside drives the pin;
- a resolved bus value.

When nobody drives a pin, a bus keeper holds its last level. Data registers load from these resolved bus values. One shared output enable covers both B ports, so the processor side can turn the B side around and load both B registers from memory.

Top module: `bus_exchanger_3p`

## Requirements
- R1: While rst_ni is low, both output-enable flags are 0, all four data registers and all three keepers are cleared to zero, and the select is cleared to pick the B2 return path.
- R2: On a rising edge, each data register loads the resolved bus value of its source port when its load enable is low. When the enable is high, the register keeps its value. The registers are wired as follows:
  - A feeds ld_ab1_ni and ld_ab2_ni;
  - B1 feeds ld_b1a_ni;
  - B2 feeds ld_b2a_ni.
- R3: If sel_i was 1 at the last edge, a_o shows the B1-to-A register. If it was 0, a_o shows the B2-to-A register.
- R4: a_oe_o is 1 exactly in the cycles following an edge at which oe_a_ni was low.
- R5: One output-enable flag, b_oe_o, covers both B ports. It is 1 exactly in the cycles following an edge at which oe_b_ni was low.
- R6: When both A-to-B load enables are low at the same edge, both B registers take the same A bus value.
- R7: Each resolved bus value is chosen in this order:
  - the block's own output, while its enable flag is 1;
  - otherwise the external value, while its valid flag is 1;
  - otherwise the value the bus had at the previous edge.
- R8: A register loaded while its port is enabled shows the new value on the port right after that same edge.
- R9: A change of sel_i switches a_o at the next edge, with no data load needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_ab1_ni | input | 1 | Load enable for the A-to-B1 register, active low |
| ld_ab2_ni | input | 1 | Load enable for the A-to-B2 register, active low |
| ld_b1a_ni | input | 1 | Load enable for the B1-to-A register, active low |
| ld_b2a_ni | input | 1 | Load enable for the B2-to-A register, active low |
| sel_i | input | 1 | Return path select: 1 picks B1, 0 picks B2 |
| oe_a_ni | input | 1 | Output enable for port A, active low, registered |
| oe_b_ni | input | 1 | Output enable for both B ports, active low, registered |
| a_i | input | W | External value on port A |
| a_vld_i | input | 1 | External driver active on port A |
| b1_i | input | W | External value on port B1 |
| b1_vld_i | input | 1 | External driver active on port B1 |
| b2_i | input | W | External value on port B2 |
| b2_vld_i | input | 1 | External driver active on port B2 |
| a_o | output | W | Value the block drives on port A |
| a_oe_o | output | 1 | Port A driven by the block |
| b1_o | output | W | Value the block drives on port B1 |
| b2_o | output | W | Value the block drives on port B2 |
| b_oe_o | output | 1 | Both B ports driven by the block |
| a_bus_o | output | W | Resolved level on port A |
| b1_bus_o | output | W | Resolved level on port B1 |
| b2_bus_o | output | W | Resolved level on port B2 |

## Verification
A corrupt data register stays hidden until its port is enabled or its value is routed to A. A corrupt select or enable flag shows in the very next cycle as the wrong register on a_o or as a wrong enable flag. A keeper that fails to hold shows only in a cycle where nobody drives the pin. The bench therefore leaves each port undriven on purpose and compares a_o, b1_o, b2_o and all three resolved buses every cycle against a reference model.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int NPORT = 3;
  localparam int NREG  = 4;
  localparam int P_A   = 0;
  localparam int P_B1  = 1;
  localparam int P_B2  = 2;

  typedef struct packed {
    logic sel_b1;
    logic a_en;
    logic b_en;
  } bx_ctrl_t;

  // source port of each data register: 0 A->B1, 1 A->B2, 2 B1->A, 3 B2->A
  function automatic int src_port(input int k);
    case (k)
      0, 1:    return P_A;
      2:       return P_B1;
      default: return P_B2;
    endcase
  endfunction
endpackage

// File: rtl/bx_data_reg.sv
module bx_data_reg #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (!ld_ni) q_o <= d_i;
  end
endmodule

// File: rtl/bx_ctrl_reg.sv
module bx_ctrl_reg
  import bx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sel_i,
  input  logic     oe_a_ni,
  input  logic     oe_b_ni,
  output bx_ctrl_t ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '{sel_b1: 1'b0, a_en: 1'b0, b_en: 1'b0};
    end else begin
      ctrl_o.sel_b1 <= sel_i;
      ctrl_o.a_en   <= ~oe_a_ni;
      ctrl_o.b_en   <= ~oe_b_ni;
    end
  end
endmodule

// File: rtl/bx_keeper.sv
module bx_keeper #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         drv_en_i,
  input  logic [W-1:0] drv_val_i,
  input  logic         ext_vld_i,
  input  logic [W-1:0] ext_val_i,
  output logic [W-1:0] bus_o
);
  logic [W-1:0] held_q;

  // own driver wins, then external driver, then the held level
  always_comb begin
    if (drv_en_i)       bus_o = drv_val_i;
    else if (ext_vld_i) bus_o = ext_val_i;
    else                bus_o = held_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= bus_o;
  end
endmodule

// File: rtl/bus_exchanger_3p.sv
module bus_exchanger_3p
  import bx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_ab1_ni,
  input  logic         ld_ab2_ni,
  input  logic         ld_b1a_ni,
  input  logic         ld_b2a_ni,
  input  logic         sel_i,
  input  logic         oe_a_ni,
  input  logic         oe_b_ni,
  input  logic [W-1:0] a_i,
  input  logic         a_vld_i,
  input  logic [W-1:0] b1_i,
  input  logic         b1_vld_i,
  input  logic [W-1:0] b2_i,
  input  logic         b2_vld_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  output logic [W-1:0] b1_o,
  output logic [W-1:0] b2_o,
  output logic         b_oe_o,
  output logic [W-1:0] a_bus_o,
  output logic [W-1:0] b1_bus_o,
  output logic [W-1:0] b2_bus_o
);
  bx_ctrl_t     ctrl;
  logic [W-1:0] reg_q   [NREG];
  logic [NREG-1:0] ld_n;
  logic [W-1:0] bus     [NPORT];
  logic [W-1:0] own_val [NPORT];
  logic [W-1:0] ext_val [NPORT];
  logic [NPORT-1:0] own_en;
  logic [NPORT-1:0] ext_vld;

  assign ld_n = {ld_b2a_ni, ld_b1a_ni, ld_ab2_ni, ld_ab1_ni};

  bx_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .oe_a_ni (oe_a_ni),
    .oe_b_ni (oe_b_ni),
    .ctrl_o  (ctrl)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    bx_data_reg #(.W(W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_ni  (ld_n[k]),
      .d_i    (bus[src_port(k)]),
      .q_o    (reg_q[k])
    );
  end

  assign own_val[P_A]  = ctrl.sel_b1 ? reg_q[2] : reg_q[3];
  assign own_val[P_B1] = reg_q[0];
  assign own_val[P_B2] = reg_q[1];
  assign own_en        = {ctrl.b_en, ctrl.b_en, ctrl.a_en};
  assign ext_val[P_A]  = a_i;
  assign ext_val[P_B1] = b1_i;
  assign ext_val[P_B2] = b2_i;
  assign ext_vld       = {b2_vld_i, b1_vld_i, a_vld_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    bx_keeper #(.W(W)) u_keep (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .drv_en_i  (own_en[p]),
      .drv_val_i (own_val[p]),
      .ext_vld_i (ext_vld[p]),
      .ext_val_i (ext_val[p]),
      .bus_o     (bus[p])
    );
  end

  assign a_o      = own_val[P_A];
  assign a_oe_o   = ctrl.a_en;
  assign b1_o     = own_val[P_B1];
  assign b2_o     = own_val[P_B2];
  assign b_oe_o   = ctrl.b_en;
  assign a_bus_o  = bus[P_A];
  assign b1_bus_o = bus[P_B1];
  assign b2_bus_o = bus[P_B2];
endmodule

// File: rtl/bx_checker.sv
module bx_checker #(
  parameter int W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ld_ab1_ni,
  input logic         ld_ab2_ni,
  input logic         ld_b1a_ni,
  input logic         ld_b2a_ni,
  input logic         sel_i,
  input logic         oe_a_ni,
  input logic         oe_b_ni,
  input logic         a_vld_i,
  input logic         b1_vld_i,
  input logic [W-1:0] a_o,
  input logic         a_oe_o,
  input logic [W-1:0] b1_o,
  input logic [W-1:0] b2_o,
  input logic         b_oe_o,
  input logic [W-1:0] a_bus_o,
  input logic [W-1:0] b1_bus_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!a_oe_o && !b_oe_o));

  assert_hold_ab1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ab1_ni |=> $stable(b1_o));

  assert_load_ab1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ab1_ni |=> b1_o == $past(a_bus_o));

  assert_path_b1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !ld_b1a_ni) |=> a_o == $past(b1_bus_o));

  assert_a_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> a_oe_o == !$past(oe_a_ni));

  assert_b_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> b_oe_o == !$past(oe_b_ni));

  assert_dual_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_ab1_ni && !ld_ab2_ni) |=> b1_o == b2_o);

  assert_keep_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_oe_o && !a_vld_i) |-> a_bus_o == $past(a_bus_o));

  assert_keep_b1_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!b_oe_o && !b1_vld_i) |-> b1_bus_o == $past(b1_bus_o));

  assert_path_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_b1a_ni && ld_b2a_ni && $stable(sel_i)) |=> $stable(a_o));
endmodule

bind bus_exchanger_3p bx_checker #(.W(W)) u_bx_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ld_ab1_ni (ld_ab1_ni),
  .ld_ab2_ni (ld_ab2_ni),
  .ld_b1a_ni (ld_b1a_ni),
  .ld_b2a_ni (ld_b2a_ni),
  .sel_i     (sel_i),
  .oe_a_ni   (oe_a_ni),
  .oe_b_ni   (oe_b_ni),
  .a_vld_i   (a_vld_i),
  .b1_vld_i  (b1_vld_i),
  .a_o       (a_o),
  .a_oe_o    (a_oe_o),
  .b1_o      (b1_o),
  .b2_o      (b2_o),
  .b_oe_o    (b_oe_o),
  .a_bus_o   (a_bus_o),
  .b1_bus_o  (b1_bus_o)
);

// File: tb/bus_exchanger_3p_test.sv
module bus_exchanger_3p_test;
  localparam int W = 12;

  typedef struct {
    logic [W-1:0] a_o, b1_o, b2_o, a_bus, b1_bus, b2_bus;
    logic a_oe, b_oe;
    string tag;
  } exp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ld_ab1_ni = 1, ld_ab2_ni = 1, ld_b1a_ni = 1, ld_b2a_ni = 1;
  logic sel_i = 0, oe_a_ni = 1, oe_b_ni = 1;
  logic [W-1:0] a_i = '0, b1_i = '0, b2_i = '0;
  logic a_vld_i = 0, b1_vld_i = 0, b2_vld_i = 0;
  logic [W-1:0] a_o, b1_o, b2_o, a_bus_o, b1_bus_o, b2_bus_o;
  logic a_oe_o, b_oe_o;

  int total = 0, bad = 0;
  exp_t q[$];

  // reference state
  logic [W-1:0] m_ab1, m_ab2, m_b1a, m_b2a, h_a, h_b1, h_b2;
  logic m_sel, m_aen, m_ben;

  always #2 clk_i = ~clk_i;

  bus_exchanger_3p #(.W(W)) uut (.*);

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model_view(string tag);
    exp_t e;
    e.a_o    = m_sel ? m_b1a : m_b2a;
    e.b1_o   = m_ab1;
    e.b2_o   = m_ab2;
    e.a_oe   = m_aen;
    e.b_oe   = m_ben;
    e.a_bus  = m_aen ? e.a_o : (a_vld_i ? a_i : h_a);
    e.b1_bus = m_ben ? m_ab1 : (b1_vld_i ? b1_i : h_b1);
    e.b2_bus = m_ben ? m_ab2 : (b2_vld_i ? b2_i : h_b2);
    e.tag    = tag;
    return e;
  endfunction

  task automatic model_reset();
    m_ab1 = '0; m_ab2 = '0; m_b1a = '0; m_b2a = '0;
    h_a = '0; h_b1 = '0; h_b2 = '0;
    m_sel = 0; m_aen = 0; m_ben = 0;
  endtask

  // apply inputs at negedge, advance the model at posedge, queue the expectation
  task automatic step(input logic lab1, lab2, lb1a, lb2a, sel, oea_n, oeb_n,
                      input logic av, input logic [W-1:0] ad,
                      input logic b1v, input logic [W-1:0] b1d,
                      input logic b2v, input logic [W-1:0] b2d, input string tag);
    exp_t pre;
    @(negedge clk_i);
    ld_ab1_ni = lab1; ld_ab2_ni = lab2; ld_b1a_ni = lb1a; ld_b2a_ni = lb2a;
    sel_i = sel; oe_a_ni = oea_n; oe_b_ni = oeb_n;
    a_vld_i = av; a_i = ad; b1_vld_i = b1v; b1_i = b1d; b2_vld_i = b2v; b2_i = b2d;
    pre = model_view(tag);
    @(posedge clk_i);
    if (!lab1) m_ab1 = pre.a_bus;
    if (!lab2) m_ab2 = pre.a_bus;
    if (!lb1a) m_b1a = pre.b1_bus;
    if (!lb2a) m_b2a = pre.b2_bus;
    h_a = pre.a_bus; h_b1 = pre.b1_bus; h_b2 = pre.b2_bus;
    m_sel = sel; m_aen = !oea_n; m_ben = !oeb_n;
    q.push_back(model_view(tag));
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk_i);
      #1;
      while (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "a_o", a_o, e.a_o);
        chk(e.tag, "a_oe_o", {{(W-1){1'b0}}, a_oe_o}, {{(W-1){1'b0}}, e.a_oe});
        chk(e.tag, "b1_o", b1_o, e.b1_o);
        chk(e.tag, "b2_o", b2_o, e.b2_o);
        chk(e.tag, "b_oe_o", {{(W-1){1'b0}}, b_oe_o}, {{(W-1){1'b0}}, e.b_oe});
        chk(e.tag, "a_bus_o", a_bus_o, e.a_bus);
        chk(e.tag, "b1_bus_o", b1_bus_o, e.b1_bus);
        chk(e.tag, "b2_bus_o", b2_bus_o, e.b2_bus);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    logic [15:0] lfsr = 16'hACE1;
    model_reset();
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state seen with reset still asserted
    chk("R1", "a_oe_o", {{(W-1){1'b0}}, a_oe_o}, '0);
    chk("R1", "b_oe_o", {{(W-1){1'b0}}, b_oe_o}, '0);
    chk("R1", "a_o", a_o, '0);
    chk("R1", "b1_o", b1_o, '0);
    chk("R1", "b2_o", b2_o, '0);
    chk("R1", "a_bus_o", a_bus_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1,1,1,1,0,1,1, 0,'0, 0,'0, 0,'0, "R1");
    // R6: one A value into both B registers, B side still off
    step(0,0,1,1,0,1,1, 1,12'hABC, 0,'0, 0,'0, "R6");
    // R5: one enable turns on both B ports
    step(1,1,1,1,0,1,0, 0,'0, 0,'0, 0,'0, "R5");
    // R8/R2: load only A->B1 while B enabled, appears after same edge
    step(0,1,1,1,0,1,0, 1,12'h123, 0,'0, 0,'0, "R8");
    step(1,1,1,1,0,1,0, 1,12'h777, 0,'0, 0,'0, "R2");
    // turn B off and load both return registers from memory
    step(1,1,1,1,0,1,1, 0,'0, 0,'0, 0,'0, "R5");
    step(1,1,0,0,0,1,1, 0,'0, 1,12'h5A5, 1,12'h3C3, "R2");
    // R4/R3: enable A with B1 path
    step(1,1,1,1,1,0,1, 0,'0, 0,'0, 0,'0, "R3");
    // R9: path switch alone
    step(1,1,1,1,0,0,1, 0,'0, 0,'0, 0,'0, "R9");
    step(1,1,1,1,1,0,1, 0,'0, 0,'0, 0,'0, "R9");
    // R7: buses left floating keep their levels
    step(1,1,1,1,1,1,1, 0,'0, 0,'0, 0,'0, "R7");
    step(1,1,1,1,1,1,1, 0,'0, 0,'0, 0,'0, "R7");
    step(1,1,0,1,1,1,1, 0,'0, 0,'0, 0,'0, "R7");
    // R4: A disabled again
    step(1,1,1,1,0,1,1, 1,12'h0F0, 0,'0, 0,'0, "R4");
    // mixed traffic; drive a side externally only while the block is off there
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d = lfsr[W-1:0] ^ W'(i * 37);
      step(lfsr[0], lfsr[1], lfsr[2], lfsr[3], lfsr[4], lfsr[5], lfsr[6],
           !m_aen && lfsr[7], d,
           !m_ben && lfsr[8], ~d,
           !m_ben && lfsr[9], d ^ 12'h5A5, "R2");
    end
    @(posedge clk_i);
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule